// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM with Byte Lanes

This block is a synthesizable synchronous static memory with a two-stage read pipeline and a short internal burst counter. The data word is 18 bits wide and split into two 9-bit lanes, each with 8 data bits and one parity bit. Every control input except the output enable is sampled on the rising clock edge. A read returns its word from an output register one edge after the access was sampled. A write stores its word through per-lane enables that are decoded from a global write input, a byte-write gate and one enable per lane.

An access opens in one of two ways. The read-only strobe always starts a read and is blocked by the master chip select. The general strobe samples the write controls on its own edge. Once an access is open, the advance input steps a 2-bit burst counter through either a linear or an interleaved order; with advance high, the current address is repeated. The data bus is split into an input bus, an output bus and a drive-enable flag in place of a bidirectional pin. The drive-enable flag is gated combinationally by an asynchronous, active-low output enable. After a deselect, the output keeps driving for one extra cycle before it releases. The depth is set by the address-width parameter.

Top module: `pburst_sram`

## Requirements
- R1: A read sampled on rising edge n puts the stored word on `rdata` after edge n+1. With `oe_n` low, `rdata_en` is high in that cycle.
- R2: On a write-capable edge, `gw_n` low writes all 18 bits, whatever `bwe_n` and `lane_we_n` are.
- R3: With `gw_n` high, lane i is written only when `bwe_n` is low and `lane_we_n[i]` is low. Lane 0 is `wdata[8:0]` and lane 1 is `wdata[17:9]`. If `bwe_n` is high, or both lane enables are high, the access is a read.
- R4: An access opened by `strobe_rd_n` low (with `sel_n` low) is always a read and ignores every write control. With `strobe_rd_n` high, an access opened by `strobe_rw_n` low samples the write controls on that same edge. `sel_n` high blocks `strobe_rd_n` but not `strobe_rw_n`.
- R5: An opening edge begins an access only when `sel_n` is low, `sel_hi` is high and `sel_lo_n` is low. An opening edge with any select inactive is a deselect, and it ends the open burst.
- R6: On an edge with no opening strobe while an access is open, `adv_n` low moves to the next burst address and `adv_n` high repeats the current one. Only address bits [1:0] change. With `seq_linear`=1 the k-th address is (start+k) mod 4; with `seq_linear`=0 it is start XOR k. `adv_n` is ignored on an opening edge.
- R7: After an edge on which any lane is written, `rdata_en` is low in the following cycle, whatever `oe_n` is.
- R8: `oe_n` high forces `rdata_en` low at once, without waiting for a clock edge. `oe_n` low restores it the same way.
- R9: Deselect lasts two cycles. After a deselect on edge n that follows a read on edge n-1, `rdata_en` stays high after edge n+1 and still shows the last read word. It is low after edge n+2.
- R10: Write data is captured on the same edge as its address. A read of that address on the next edge returns the new word.
- R11: After reset, `rdata_en` is low and no access is open. Edges with no opening strobe then perform no access and leave the output released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | AW | Word address, taken on opening edges |
| sel_n | input | 1 | Master select, active low; gates `strobe_rd_n` |
| sel_hi | input | 1 | Select, active high |
| sel_lo_n | input | 1 | Select, active low |
| strobe_rd_n | input | 1 | Opening strobe that always starts a read |
| strobe_rw_n | input | 1 | Opening strobe that samples the write controls |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, all lanes, active low |
| bwe_n | input | 1 | Byte-write gate, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| seq_linear | input | 1 | 1 = linear burst order, 0 = interleaved order |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 18 | Write data |
| rdata | output | 18 | Read data from the output register |
| rdata_en | output | 1 | High when `rdata` would be driven onto the bus |

## Verification
A wrong burst counter or a wrong captured upper address makes a later read return the word of a neighbouring location. That shows on `rdata` one edge after the faulty access. A write-decode fault leaves a lane with stale or overwritten contents, which shows up on the first read of that word. A fault in the drive pipeline shows on `rdata_en` in the first cycle after a write, a read or a deselect: the output either releases one cycle early or late, or drives during a write.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  // Command decoded from the strobes and selects on each edge
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_DESEL = 2'd1,
    CMD_START = 2'd2,
    CMD_CONT  = 2'd3
  } pbs_cmd_e;
endpackage

// File: rtl/pbs_burst_seq.sv
module pbs_burst_seq #(
  parameter int unsigned BB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [BB-1:0] start_lo,
  input  logic          step,
  input  logic          linear,
  output logic [BB-1:0] lo_o
);
  logic [BB-1:0] base_q, cnt_q, cnt_nx;

  assign cnt_nx = cnt_q + {{(BB-1){1'b0}}, step};
  assign lo_o   = load ? start_lo : (linear ? base_q + cnt_nx : base_q ^ cnt_nx);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= start_lo;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_nx;
    end
  end

  // R6: an advance moves the counter by exactly one, modulo the burst length
  assert_step_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (cnt_q == $past(cnt_q) + 1'b1))
    else $error("burst counter did not advance");
  // R6: a suspend keeps the counter
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(cnt_q))
    else $error("burst counter moved while suspended");
endmodule

// File: rtl/pbs_wr_decode.sv
module pbs_wr_decode #(
  parameter int unsigned LANES = 2
) (
  input  logic             block,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_we_n,
  output logic [LANES-1:0] lane_wr
);
  always_comb begin
    if (block)       lane_wr = '0;
    else if (!gw_n)  lane_wr = '1;
    else if (!bwe_n) lane_wr = ~lane_we_n;
    else             lane_wr = '0;
  end
endmodule

// File: rtl/pbs_lane_ram.sv
module pbs_lane_ram #(
  parameter int unsigned AW = 10,
  parameter int unsigned W  = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  q
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [W-1:0] mem [0:DEPTH-1];

  // Single port: the controller never issues a read and a write on one edge
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/pburst_sram.sv
module pburst_sram #(
  parameter int unsigned AW     = 10,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned BB     = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [AW-1:0]           addr_i,
  input  logic                    sel_n,
  input  logic                    sel_hi,
  input  logic                    sel_lo_n,
  input  logic                    strobe_rd_n,
  input  logic                    strobe_rw_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    seq_linear,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_en
);
  import pbs_pkg::*;

  localparam int unsigned DW = LANES * LANE_W;
  localparam int unsigned HW = AW - BB;

  pbs_cmd_e         cmd;
  logic             p_req, c_req, en_all, acc, step, wr_block, wr_any;
  logic [LANES-1:0] lane_wr;
  logic [BB-1:0]    lo_nx;
  logic [HW-1:0]    hi_nx;

  logic             active_q, rd_q, lin_q, out_on;
  logic [HW-1:0]    hi_q;
  logic [AW-1:0]    addr_q;
  logic [LANES-1:0] wr_q;
  logic [DW-1:0]    wdata_q;

  // Edge command decode
  assign p_req  = !strobe_rd_n && !sel_n;
  assign c_req  = !strobe_rw_n && !p_req;
  assign en_all = !sel_n && sel_hi && !sel_lo_n;

  always_comb begin
    if (p_req || c_req) cmd = en_all ? CMD_START : CMD_DESEL;
    else                cmd = active_q ? CMD_CONT : CMD_IDLE;
  end

  assign acc      = (cmd == CMD_START) || (cmd == CMD_CONT);
  assign step     = (cmd == CMD_CONT) && !adv_n;
  assign wr_block = !acc || p_req;
  assign wr_any   = |lane_wr;
  assign hi_nx    = (cmd == CMD_START) ? addr_i[AW-1:BB] : hi_q;

  pbs_wr_decode #(.LANES(LANES)) u_dec (
    .block     (wr_block),
    .gw_n      (gw_n),
    .bwe_n     (bwe_n),
    .lane_we_n (lane_we_n),
    .lane_wr   (lane_wr)
  );

  pbs_burst_seq #(.BB(BB)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .load     (cmd == CMD_START),
    .start_lo (addr_i[BB-1:0]),
    .step     (step),
    .linear   (seq_linear),
    .lo_o     (lo_nx)
  );

  // Access register stage and output drive pipeline
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      lin_q    <= 1'b0;
      out_on   <= 1'b0;
      wr_q     <= '0;
      hi_q     <= '0;
    end else begin
      if (cmd == CMD_START)      active_q <= 1'b1;
      else if (cmd == CMD_DESEL) active_q <= 1'b0;
      hi_q   <= hi_nx;
      wr_q   <= lane_wr;
      rd_q   <= acc && !wr_any;
      lin_q  <= (cmd == CMD_DESEL) && rd_q;
      out_on <= !wr_any && (rd_q || lin_q);
    end
  end

  always_ff @(posedge clk) begin
    addr_q  <= {hi_nx, lo_nx};
    wdata_q <= wdata;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pbs_lane_ram #(.AW(AW), .W(LANE_W)) u_ram (
      .clk  (clk),
      .we   (wr_q[g]),
      .re   (rd_q),
      .addr (addr_q),
      .wd   (wdata_q[g*LANE_W +: LANE_W]),
      .q    (rdata[g*LANE_W +: LANE_W])
    );
  end

  assign rdata_en = out_on && !oe_n;

  // R4: the read-only strobe never yields a lane write
  assert_p_read_R4: assert property (@(posedge clk) disable iff (rst)
    p_req |-> (lane_wr == '0))
    else $error("read-only strobe produced a write");
  // R2: global write on a general-strobe opening writes every lane
  assert_gw_all_R2: assert property (@(posedge clk) disable iff (rst)
    (c_req && en_all && !gw_n) |-> (&lane_wr))
    else $error("global write missed a lane");
  // R7: a write edge releases the output
  assert_wr_release_R7: assert property (@(posedge clk) disable iff (rst)
    wr_any |=> !rdata_en)
    else $error("output driven after a write edge");
  // R9: a deselect right after a read keeps driving one more cycle
  assert_dcd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_q && cmd == CMD_DESEL) |=> out_on)
    else $error("output released a cycle early on deselect");
  // R9: with no read pending and no linger, the output releases
  assert_dcd_off_R9: assert property (@(posedge clk) disable iff (rst)
    (!rd_q && !lin_q) |=> !out_on)
    else $error("output still driven with nothing to show");
  // R6: the upper address stays fixed through a burst
  assert_hi_fixed_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_CONT) |=> $stable(hi_q))
    else $error("upper address moved during a burst");
endmodule

// File: tb/sim_pburst_sram.sv
`timescale 1ns/100ps
module sim_pburst_sram;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  addr_i = '0;
  logic        sel_n = 1'b0, sel_hi = 1'b1, sel_lo_n = 1'b0;
  logic        strobe_rd_n = 1'b1, strobe_rw_n = 1'b1, adv_n = 1'b1;
  logic        gw_n = 1'b1, bwe_n = 1'b1;
  logic [1:0]  lane_we_n = 2'b11;
  logic        seq_linear = 1'b1, oe_n = 1'b0;
  logic [17:0] wdata = '0;
  logic [17:0] rdata;
  logic        rdata_en;

  always #2.5 clk = ~clk;

  pburst_sram u0 (
    .clk(clk), .rst(rst), .addr_i(addr_i), .sel_n(sel_n), .sel_hi(sel_hi),
    .sel_lo_n(sel_lo_n), .strobe_rd_n(strobe_rd_n), .strobe_rw_n(strobe_rw_n),
    .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n), .lane_we_n(lane_we_n),
    .seq_linear(seq_linear), .oe_n(oe_n), .wdata(wdata), .rdata(rdata),
    .rdata_en(rdata_en)
  );

  int    checks = 0, errors = 0;
  string tag = "R11";
  bit    done = 1'b0;

  // Scoreboard queues, one entry per clock edge
  bit          q_on[$];
  logic [17:0] q_dat[$];
  string       q_tag[$];

  // Reference state built from the requirements
  logic [17:0] ref_mem [0:1023];
  bit          m_act = 1'b0;
  logic [9:0]  m_start = '0;
  int          m_cnt = 0;
  int          pv = 0, pv2 = 0;          // 0 none, 1 read, 2 write, 3 deselect
  logic [17:0] pend = '0, held = '0;

  task automatic chk(input bit ok, input string t, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", t, act, exp);
    end
  endtask

  function automatic logic [1:0] seqf(input logic [1:0] b, input int k, input bit lin);
    logic [1:0] kk;
    kk = 2'(k);
    return lin ? b + kk : b ^ kk;
  endfunction

  task automatic model_edge();
    bit p, c, en, on;
    int kind, op;
    logic [9:0]  a;
    logic [1:0]  lw;
    logic [17:0] d;
    p  = !strobe_rd_n && !sel_n;
    c  = !strobe_rw_n && !p;
    en = !sel_n && sel_hi && !sel_lo_n;
    a  = '0; lw = 2'b00; d = '0;
    if (p || c) kind = en ? 2 : 1;
    else        kind = m_act ? 3 : 0;
    if (kind == 2) begin
      m_start = addr_i; m_cnt = 0; m_act = 1'b1; a = addr_i;
    end else if (kind == 3) begin
      if (!adv_n) m_cnt = (m_cnt + 1) % 4;
      a = {m_start[9:2], seqf(m_start[1:0], m_cnt, seq_linear)};
    end else if (kind == 1) m_act = 1'b0;
    if (kind >= 2 && !(kind == 2 && p))
      lw = !gw_n ? 2'b11 : (!bwe_n ? ~lane_we_n : 2'b00);
    if (kind >= 2) op = (lw != 2'b00) ? 2 : 1;
    else           op = (kind == 1) ? 3 : 0;
    if (op == 2)                    on = 1'b0;
    else if (pv == 1)               begin on = 1'b1; d = pend; end
    else if (pv == 3 && pv2 == 1)   begin on = 1'b1; d = held; end
    else                            on = 1'b0;
    if (on) held = d;
    if (op == 1) pend = ref_mem[a];
    if (op == 2) begin
      if (lw[0]) ref_mem[a][8:0]  = wdata[8:0];
      if (lw[1]) ref_mem[a][17:9] = wdata[17:9];
    end
    pv2 = pv; pv = op;
    q_on.push_back(on); q_dat.push_back(d); q_tag.push_back(tag);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    #1;
    strobe_rd_n = 1'b1; strobe_rw_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; lane_we_n = 2'b11;
    sel_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
  endtask

  // Monitor: compare one expectation per cycle
  always @(negedge clk) begin
    if (q_on.size() > 0) begin
      bit on; logic [17:0] d; string t; bit exp_en;
      on = q_on.pop_front(); d = q_dat.pop_front(); t = q_tag.pop_front();
      exp_en = on && !oe_n;
      chk(rdata_en == exp_en, {t, " drive"}, {17'd0, rdata_en}, {17'd0, exp_en});
      if (exp_en) chk(rdata === d, {t, " data"}, rdata, d);
    end
  end

  task automatic op_rw(input logic [9:0] a, input bit g, input bit b, input logic [1:0] l, input logic [17:0] w);
    strobe_rw_n = 1'b0; addr_i = a; gw_n = g; bwe_n = b; lane_we_n = l; wdata = w; tick();
  endtask
  task automatic op_rd(input logic [9:0] a);
    strobe_rd_n = 1'b0; addr_i = a; gw_n = 1'b0; bwe_n = 1'b0; lane_we_n = 2'b00; adv_n = 1'b0; tick();
  endtask
  task automatic op_cont(input bit adv, input bit g, input logic [17:0] w);
    adv_n = adv; gw_n = g; wdata = w; tick();
  endtask
  task automatic op_dsel(input bit sn, input bit sh, input bit sl);
    strobe_rw_n = 1'b0; sel_n = sn; sel_hi = sh; sel_lo_n = sl; gw_n = 1'b0; tick();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1; rst = 1'b0;
    chk(rdata_en == 1'b0, "R11 reset drive", {17'd0, rdata_en}, 18'd0);
    tag = "R11"; tick(); tick();
    tag = "R4";  strobe_rd_n = 1'b0; sel_n = 1'b1; gw_n = 1'b0; tick(); tick();
    tag = "R5";  strobe_rw_n = 1'b0; sel_lo_n = 1'b1; addr_i = 10'h010; gw_n = 1'b0; tick(); tick();

    // Linear write burst with wrap, then a read burst with suspend
    tag = "R2"; seq_linear = 1'b1;
    op_rw(10'h011, 1'b0, 1'b0, 2'b11, 18'h15A5A);
    tag = "R6";
    op_cont(1'b0, 1'b0, 18'h20001); op_cont(1'b0, 1'b0, 18'h20002);
    op_cont(1'b0, 1'b0, 18'h20003);
    tag = "R1"; op_rd(10'h011);
    tag = "R6"; op_cont(1'b0, 1'b1, '0); op_cont(1'b1, 1'b1, '0);
    op_cont(1'b0, 1'b1, '0); op_cont(1'b0, 1'b1, '0); op_cont(1'b0, 1'b1, '0);
    tag = "R9"; op_dsel(1'b1, 1'b1, 1'b0); tick(); tick();

    // Write then immediate read of the same word
    tag = "R10"; op_rw(10'h020, 1'b0, 1'b1, 2'b11, 18'h0BEEF);
    op_rd(10'h020); tick();
    tag = "R4";  op_rw(10'h020, 1'b1, 1'b0, 2'b00, 18'h11111);
    tag = "R10"; op_rd(10'h020); tick();

    // Interleaved order
    tag = "R6"; seq_linear = 1'b0;
    op_rw(10'h031, 1'b0, 1'b1, 2'b11, 18'h31000);
    op_cont(1'b0, 1'b0, 18'h30000); op_cont(1'b0, 1'b0, 18'h33000); op_cont(1'b0, 1'b0, 18'h32000);
    op_rd(10'h032); op_cont(1'b0, 1'b1, '0); op_cont(1'b0, 1'b1, '0); op_cont(1'b0, 1'b1, '0);
    seq_linear = 1'b1;

    // Lane writes and read decode
    tag = "R3";
    op_rw(10'h040, 1'b0, 1'b1, 2'b11, 18'h3FFFF);
    op_rw(10'h040, 1'b1, 1'b0, 2'b10, 18'h00000);
    op_rw(10'h040, 1'b1, 1'b1, 2'b00, 18'h12345);
    op_rw(10'h040, 1'b1, 1'b0, 2'b11, 18'h12345);
    op_rw(10'h040, 1'b1, 1'b0, 2'b01, 18'h2AAAA);
    op_rw(10'h040, 1'b1, 1'b1, 2'b11, 18'h00000);
    tick();

    // Write edge after a read releases the output even with oe_n low
    tag = "R7"; op_rd(10'h011); op_rw(10'h050, 1'b0, 1'b1, 2'b11, 18'h05555);
    op_rd(10'h050); tick();

    // Asynchronous output enable
    tag = "R8"; op_rd(10'h050); tick();
    oe_n = 1'b1; #0.5;
    chk(rdata_en == 1'b0, "R8 async release", {17'd0, rdata_en}, 18'd0);
    oe_n = 1'b0; #0.5;
    chk(rdata_en == 1'b1, "R8 async restore", {17'd0, rdata_en}, 18'd1);
    oe_n = 1'b1; tick(); oe_n = 1'b0; tick();

    // Deselect through the general strobe with the master select high
    tag = "R5"; op_rd(10'h011); op_dsel(1'b0, 1'b0, 1'b0); tick();
    tag = "R4"; op_rd(10'h012); op_dsel(1'b1, 1'b1, 1'b0); tick(); tick();

    done = 1'b1;
    chk(q_on.size() == 0, "R1 scoreboard drained", 18'(q_on.size()), 18'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule